// File: doc/BRIEF.md
# Beam-Synchronised Display Coprocessor

This block is a tiny sequencer that executes a program from its own instruction store and stays in lock-step with the video beam. It can stall until the beam has reached a chosen pixel, optionally gated by a frame count. It can issue writes into the display controller's register file, conditionally step over an instruction, and branch directly, including a one-level call and return through a link register. Whoever drives the video timing supplies the beam column, the line, the frame number and a one-cycle frame-start pulse. The controller's register file takes the writes.

Each instruction is a self-contained bus tenure. The sequencer raises a bus request and waits for the grant. It then reads one 42-bit word, executes it, and drops the request before it considers the next instruction, so the other masters get a turn after every instruction. Register writes leave on a valid/ready port. Once `wr_valid` is high, address and data hold steady until `wr_ready` is seen high on a clock edge, and `wr_valid` then falls on the next cycle. Back-pressure only lengthens the bus tenure and never drops or repeats a write. The program store is filled through a plain write port, normally while `enable` is low.

Top module: `copper_core`

## Requirements
- R1: After reset `bus_req` and `wr_valid` are low, and the first instruction fetched is the one at `start_addr`.
- R2: A fetch happens only after `bus_gnt` has answered `bus_req`. While the grant is withheld, no write appears. `bus_req` is low for at least one cycle between two instructions.
- R3: Opcode bits [41:40] select the instruction: 0 wait, 1 move, 2 skip, 3 jump. A move makes exactly one write, with address from bits [27:16] and data from bits [15:0].
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged on the next cycle.
- R5: A wait with bit 39 clear holds the program at that instruction until the pair (line, column) is at or past (bits [21:11], bits [10:0]), compared line first.
- R6: With bit 39 set, a wait or skip compares (frame, line, column) against (bits [29:22], [21:11], [10:0]), frame most significant. This lets a program act only from a given frame on.
- R7: A skip steps over the following instruction when the same compare as wait is already true, and otherwise falls through to the next one.
- R8: A jump loads the program counter from bits [7:0]. Jump mode bits [39:38] = 1 first saves the address after the jump into the link register. Mode 2 loads the program counter from the link register. Modes 0 and 3 are plain jumps.
- R9: A `frame_start` pulse makes the program restart at `start_addr` at its next instruction boundary. An instruction already fetched runs to completion first.
- R10: While `enable` is low and no instruction is in progress, `bus_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| enable | input | 1 | allow new instructions to start |
| start_addr | input | 8 | program entry point used at reset and every frame |
| frame_start | input | 1 | one-cycle pulse at the first pixel of a frame |
| beam_x | input | 11 | current beam column |
| beam_y | input | 11 | current beam line |
| frame_cnt | input | 8 | current frame number |
| prog_we | input | 1 | program store write strobe |
| prog_addr | input | 8 | program store write address |
| prog_data | input | 42 | instruction word to store |
| bus_req | output | 1 | bus request, held for one instruction |
| bus_gnt | input | 1 | bus grant |
| wr_valid | output | 1 | register write offered |
| wr_ready | input | 1 | register write accepted |
| wr_addr | output | 12 | register address of the write |
| wr_data | output | 16 | register data of the write |

## Verification
The in-line assertions watch the handshake rules on every cycle: write payload stability under back-pressure (R4), a single beat per move (R3), the request dropping after each instruction (R2), the idle request staying low with enable off (R10), and the reload at a frame edge (R9). The control-flow semantics can only be shown by the bench scenarios, which compare the order and beam position of every write over five frames against an expected list. These cover a wait holding until a pixel (R5), a write gated to later frames (R6), skip taken and not taken (R7), and call and return (R8).

// File: rtl/copper_pkg.sv
package copper_pkg;
  localparam int INSTR_W   = 42;
  localparam int OP_LSB    = 40;
  localparam int FEN_BIT   = 39;
  localparam int JMODE_LSB = 38;

  typedef enum logic [1:0] {
    OP_WAIT = 2'd0,
    OP_MOVE = 2'd1,
    OP_SKIP = 2'd2,
    OP_JUMP = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    JM_GO   = 2'd0,
    JM_CALL = 2'd1,
    JM_RET  = 2'd2,
    JM_GO2  = 2'd3
  } jmode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_REQ   = 2'd1,
    S_FETCH = 2'd2,
    S_EXEC  = 2'd3
  } cop_state_e;
endpackage

// File: rtl/cop_imem.sv
module cop_imem #(
  parameter int AW = 8,
  parameter int DW = 42
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cop_cmp.sv
module cop_cmp
  import copper_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 11,
  parameter int F_W = 8
) (
  input  logic [X_W-1:0]     beam_x,
  input  logic [Y_W-1:0]     beam_y,
  input  logic [F_W-1:0]     frame_cnt,
  input  logic [INSTR_W-1:0] instr,
  output logic               reached
);
  localparam int X_LSB = 0;
  localparam int Y_LSB = X_W;
  localparam int F_LSB = X_W + Y_W;
  localparam int PW    = F_W + Y_W + X_W;

  logic [PW-1:0] here, goal;
  logic          use_frame;

  always_comb begin
    use_frame = instr[FEN_BIT];
    here = {frame_cnt, beam_y, beam_x};
    goal = {instr[F_LSB +: F_W], instr[Y_LSB +: Y_W], instr[X_LSB +: X_W]};
    if (!use_frame) begin
      here[PW-1 -: F_W] = '0;
      goal[PW-1 -: F_W] = '0;
    end
    reached = (here >= goal);
  end
endmodule

// File: rtl/copper_core.sv
module copper_core
  import copper_pkg::*;
#(
  parameter int X_W  = 11,
  parameter int Y_W  = 11,
  parameter int F_W  = 8,
  parameter int PC_W = 8,
  parameter int RA_W = 12,
  parameter int RD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [PC_W-1:0]    start_addr,
  input  logic               frame_start,
  input  logic [X_W-1:0]     beam_x,
  input  logic [Y_W-1:0]     beam_y,
  input  logic [F_W-1:0]     frame_cnt,
  input  logic               prog_we,
  input  logic [PC_W-1:0]    prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [RA_W-1:0]    wr_addr,
  output logic [RD_W-1:0]    wr_data
);
  localparam int MD_LSB = 0;
  localparam int MA_LSB = RD_W;

  cop_state_e         st;
  logic [PC_W-1:0]    pc, link;
  logic               pend;
  logic [INSTR_W-1:0] ir;
  logic               reached;
  op_e                op;
  jmode_e             jm;
  logic [PC_W-1:0]    pc_next1, pc_next2;

  cop_imem #(.AW(PC_W), .DW(INSTR_W)) u_imem (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .re    (st == S_FETCH),
    .raddr (pc),
    .rdata (ir)
  );

  cop_cmp #(.X_W(X_W), .Y_W(Y_W), .F_W(F_W)) u_cmp (
    .beam_x    (beam_x),
    .beam_y    (beam_y),
    .frame_cnt (frame_cnt),
    .instr     (ir),
    .reached   (reached)
  );

  assign op       = op_e'(ir[OP_LSB +: 2]);
  assign jm       = jmode_e'(ir[JMODE_LSB +: 2]);
  assign pc_next1 = pc + PC_W'(1);
  assign pc_next2 = pc + PC_W'(2);
  assign bus_req  = (st != S_IDLE);
  assign wr_valid = (st == S_EXEC) && (op == OP_MOVE);
  assign wr_addr  = ir[MA_LSB +: RA_W];
  assign wr_data  = ir[MD_LSB +: RD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pc   <= '0;
      link <= '0;
      pend <= 1'b1;
    end else begin
      case (st)
        S_IDLE: begin
          if (frame_start || pend) begin
            pc   <= start_addr;
            pend <= 1'b0;
          end else if (enable) begin
            st <= S_REQ;
          end
        end
        S_REQ: begin
          if (frame_start || pend) begin
            pc   <= start_addr;
            pend <= 1'b0;
          end
          if (bus_gnt) st <= S_FETCH;
        end
        S_FETCH: begin
          if (frame_start) pend <= 1'b1;
          st <= S_EXEC;
        end
        default: begin
          if (frame_start) pend <= 1'b1;
          case (op)
            OP_MOVE: begin
              if (wr_ready) begin
                pc <= pc_next1;
                st <= S_IDLE;
              end
            end
            OP_WAIT: begin
              if (reached) pc <= pc_next1;
              st <= S_IDLE;
            end
            OP_SKIP: begin
              pc <= reached ? pc_next2 : pc_next1;
              st <= S_IDLE;
            end
            default: begin
              case (jm)
                JM_CALL: begin
                  link <= pc_next1;
                  pc   <= ir[PC_W-1:0];
                end
                JM_RET:  pc <= link;
                default: pc <= ir[PC_W-1:0];
              endcase
              st <= S_IDLE;
            end
          endcase
        end
      endcase
    end
  end

  // R4: stalled write keeps its payload
  a_r4_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R3: one accepted beat per move
  a_r3_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_valid);

  // R2: bus released after each instruction
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !bus_req);

  // R10: no request while disabled and idle
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !bus_req) |=> !bus_req);

  // R9: frame edge seen while idle restarts the program
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && frame_start) |=> (pc == $past(start_addr)));
endmodule

// File: tb/copper_core_tb.sv
module copper_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINE  = 40;
  localparam int LINES = 10;
  localparam int NEXP  = 6;

  // {addr[11:0], data[15:0], min linear beam position[15:0]}
  localparam logic [43:0] EXP [NEXP] = '{
    {12'h010, 16'h1111, 16'd0},
    {12'h011, 16'h2222, 16'd85},
    {12'h012, 16'h3333, 16'd0},
    {12'h013, 16'h4444, 16'd0},
    {12'h014, 16'h5555, 16'd0},
    {12'h015, 16'h6666, 16'd0}
  };

  logic        clk = 0, rst_n = 0, enable = 0;
  logic [7:0]  start_addr = 0;
  logic [10:0] bx = 0, by = 0;
  logic [7:0]  bf = 0;
  logic        run = 0;
  logic        prog_we = 0;
  logic [7:0]  prog_addr = 0;
  logic [41:0] prog_data = 0;
  logic        bus_gnt = 1, wr_ready = 1;
  logic        bus_req, wr_valid, frame_start;
  logic [11:0] wr_addr;
  logic [15:0] wr_data;

  int tests = 0, fails = 0;
  int idx = 0, cur_frame = 0;
  bit started = 0, done = 0, prev_stall = 0;
  logic [11:0] prev_a;
  logic [15:0] prev_d;

  assign frame_start = run && (bx == 0) && (by == 0);

  always #(CLK_PERIOD/2) clk = ~clk;

  copper_core u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_addr(start_addr),
    .frame_start(frame_start), .beam_x(bx), .beam_y(by), .frame_cnt(bf),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [41:0] i_move(input logic [11:0] a, input logic [15:0] d);
    return {2'd1, 12'd0, a, d};
  endfunction
  function automatic logic [41:0] i_cmp(input logic [1:0] op, input bit fen,
                                        input logic [7:0] f, input logic [10:0] y,
                                        input logic [10:0] x);
    return {op, fen, 9'd0, f, y, x};
  endfunction
  function automatic logic [41:0] i_jump(input logic [1:0] mode, input logic [7:0] t);
    return {2'd3, mode, 30'd0, t};
  endfunction

  function automatic string req_of(input int k);
    case (k)
      0: return "R3";
      1: return "R5";
      2: return "R7";
      3: return "R8";
      4: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load(input int a, input logic [41:0] w);
    @(negedge clk);
    prog_we = 1; prog_addr = 8'(a); prog_data = w;
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // beam and back-pressure drivers
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (run) begin
        if (bx == LINE-1) begin
          bx = 0;
          if (by == LINES-1) begin by = 0; bf = bf + 1; end
          else by = by + 1;
        end else bx = bx + 1;
      end
      wr_ready = ((bx % 3) != 1);
    end
  end

  // write monitor
  initial begin
    forever begin
      @(negedge clk);
      if (frame_start) begin
        if (started) begin
          // R6 R9: per-frame write count (6666 only from frame 3)
          check(idx == ((cur_frame >= 3) ? 6 : 5), "R9",
                $sformatf("frame %0d write count", cur_frame), idx,
                (cur_frame >= 3) ? 6 : 5);
          if (bf == 5) done = 1;
        end
        cur_frame = bf; idx = 0; started = 1;
      end
      if (prev_stall)
        check(wr_valid && wr_addr == prev_a && wr_data == prev_d, "R4",
              "payload held under stall", {wr_valid, wr_addr, wr_data},
              {1'b1, prev_a, prev_d});
      prev_stall = wr_valid && !wr_ready;
      prev_a = wr_addr; prev_d = wr_data;
      if (wr_valid && wr_ready) begin
        if (idx < NEXP) begin
          check({wr_addr, wr_data} == EXP[idx][43:16], req_of(idx),
                $sformatf("frame %0d write %0d", cur_frame, idx),
                {wr_addr, wr_data}, EXP[idx][43:16]);
          check(int'(by) * LINE + int'(bx) >= int'(EXP[idx][15:0]), req_of(idx),
                "write beam position", int'(by) * LINE + int'(bx), EXP[idx][15:0]);
        end else begin
          check(0, "R7", "unexpected extra write", {wr_addr, wr_data}, 0);
        end
        idx++;
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!bus_req, "R1", "bus_req after reset", bus_req, 0);
    check(!wr_valid, "R1", "wr_valid after reset", wr_valid, 0);

    load(0,  i_move(12'h010, 16'h1111));
    load(1,  i_cmp(2'd0, 0, 8'd0, 11'd2, 11'd5));
    load(2,  i_move(12'h011, 16'h2222));
    load(3,  i_cmp(2'd2, 0, 8'd0, 11'd0, 11'd0));
    load(4,  i_move(12'h0EE, 16'hDEAD));
    load(5,  i_cmp(2'd2, 0, 8'd0, 11'd9, 11'd39));
    load(6,  i_move(12'h012, 16'h3333));
    load(7,  i_jump(2'd1, 8'd20));
    load(8,  i_move(12'h014, 16'h5555));
    load(9,  i_cmp(2'd0, 1, 8'd3, 11'd0, 11'd0));
    load(10, i_move(12'h015, 16'h6666));
    load(11, i_cmp(2'd0, 0, 8'd0, 11'd15, 11'd0));
    load(20, i_move(12'h013, 16'h4444));
    load(21, i_jump(2'd2, 8'd0));

    repeat (4) @(negedge clk);
    check(!bus_req, "R10", "bus_req with enable low", bus_req, 0);

    bus_gnt = 0;
    enable = 1;
    repeat (3) @(negedge clk);
    check(bus_req, "R2", "bus_req raised", bus_req, 1);
    run = 1;
    repeat (8) @(negedge clk);
    check(!wr_valid, "R2", "no write without grant", wr_valid, 0);
    check(bus_req, "R2", "request held without grant", bus_req, 1);
    bus_gnt = 1;

    wait (done);
    @(negedge clk);
    summary();
  end
endmodule